// File: doc/BRIEF.md
# Buffered PWM Timer Bank

This block holds five down-counting timer channels. Each channel has a period (count) value and a compare value. Software writes both into buffer registers. The buffers reach the running counter only when the channel reloads or when software holds the channel's load bit. One shared control word gives each channel four controls: run, load, polarity flip and repeat. Four channels drive a PWM pin. The last channel is a timer only and has no pin. Every channel gives a one-cycle expiry pulse that an interrupt controller can use.

Each channel has a tick-enable input, made by a prescaler outside the block. The counter moves only on a clock edge where that enable is high. A period lasts the buffered count plus one ticks. The output is high while the counter is above the active compare value, or always when the compare value is all ones (full duty). The polarity bit flips the pin.

The register bus is a plain control port with no back-pressure. A write takes effect at the clock edge where `reg_wr` is high. Reads are combinational from `reg_addr`.

Top module: `pwm_timer_bank`

## Requirements
- R1: Register map, byte addresses. The control word is at 0x08. The count buffer of channel c is at 0x0C+12c and its compare buffer is at 0x10+12c. A read returns the buffer contents, zero-extended. Any other address reads as zero.
- R2: Control word layout. Channel 0 owns bits 3:0. Channel k≥1 owns bits 4(k+1)+3 down to 4(k+1). Inside a nibble, bit 0 is run, bit 1 is load, bit 2 is polarity flip and bit 3 is repeat. The last channel has no polarity bit and its repeat bit is bit 2 of its nibble (bit 22). Bits 7:4, bit 23 and bits 31:24 ignore writes and read as zero.
- R3: After reset every buffer and counter is zero. The control word is 0x00044404, which sets the polarity bits of the four pin channels.
- R4: While load is set, a channel copies both buffers into its active registers at every edge. It does not count or expire. Load also clears a stopped one-shot.
- R5: A running channel decrements on each tick. With run clear, or with no tick, the counter holds its value.
- R6: A tick taken while the counter is zero gives a one-cycle pulse on `expire_o[c]` in the next cycle. With repeat set, the channel reloads both active registers from the buffers at that edge, so one period is the count buffer plus one ticks.
- R7: With repeat clear, an expiry leaves the counter at zero. No further expiry pulse comes until a load.
- R8: `pwm_o[c]` = (run AND (counter > compare OR compare == all ones)) XOR polarity. With run clear the pin therefore sits at the polarity level.
- R9: The last channel counts and expires like the others but drives no pin.
- R10: A buffer write does not change the active counter or compare value until the next reload or load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | NCHAN | Per-channel count enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` |
| pwm_o | output | NCHAN-1 | PWM pins of the channels that have one |
| expire_o | output | NCHAN | One-cycle expiry pulse per channel |

## Verification
The assertions assume that the buffers only move in a cycle with a write strobe. They also assume that tick enables and control bits are sampled once per clock edge with no further qualification, so a tick held high for many cycles counts once per cycle. The stimulus changes every input half a cycle away from the active edge. It keeps the reset low across several edges before release. The tick patterns it uses are all-high, one-in-three and idle, and they cover held loads, one-shot stops, buffer writes during a period and writes to the unused control bits.

// File: rtl/pwmt_pkg.sv
`timescale 1ns/1ps
package pwmt_pkg;

  localparam int unsigned CTRL_OFS = 8;

  // per-channel control as seen by a counter
  typedef struct packed {
    logic run;
    logic load;
    logic inv;
    logic rep;
  } chan_ctl_t;

  // nibble base inside the control word: one empty nibble after channel 0
  function automatic int unsigned nib_lsb(input int unsigned ch);
    return (ch == 0) ? 0 : 4 * (ch + 1);
  endfunction

  // repeat bit: sits in the polarity slot for the last (pinless) channel
  function automatic int unsigned rep_bit(input int unsigned ch, input int unsigned last);
    return (ch == last) ? nib_lsb(ch) + 2 : nib_lsb(ch) + 3;
  endfunction

  function automatic int unsigned cnt_ofs(input int unsigned ch);
    return 12 + 12 * ch;
  endfunction

  function automatic int unsigned cmp_ofs(input int unsigned ch);
    return 16 + 12 * ch;
  endfunction

endpackage

// File: rtl/pwmt_regs.sv
`timescale 1ns/1ps
module pwmt_regs
  import pwmt_pkg::*;
#(
  parameter int NCHAN = 5,
  parameter int CW    = 32,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [AW-1:0]               addr,
  input  logic [DW-1:0]               wdata,
  output logic [DW-1:0]               rdata,
  output chan_ctl_t [NCHAN-1:0]       ctl,
  output logic [NCHAN-1:0][CW-1:0]    cnt_buf,
  output logic [NCHAN-1:0][CW-1:0]    cmp_buf
);

  localparam int LAST = NCHAN - 1;

  function automatic logic [DW-1:0] build_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int c = 0; c < NCHAN; c++) begin
      m[nib_lsb(c)]     = 1'b1;
      m[nib_lsb(c) + 1] = 1'b1;
      m[nib_lsb(c) + 2] = 1'b1;
      if (c != LAST) m[nib_lsb(c) + 3] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [DW-1:0] build_reset();
    logic [DW-1:0] m;
    m = '0;
    for (int c = 0; c < LAST; c++) m[nib_lsb(c) + 2] = 1'b1;
    return m;
  endfunction

  localparam logic [DW-1:0] CTRL_MASK = build_mask();
  localparam logic [DW-1:0] CTRL_RST  = build_reset();

  logic [DW-1:0] ctrl_q;
  wire ctrl_hit = (addr == AW'(CTRL_OFS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ctrl_q <= CTRL_RST;
    else if (wr_en && ctrl_hit) ctrl_q <= wdata & CTRL_MASK;
  end

  for (genvar c = 0; c < NCHAN; c++) begin : g_ch
    localparam int NB = nib_lsb(c);
    localparam int RB = rep_bit(c, LAST);
    wire cnt_hit = (addr == AW'(cnt_ofs(c)));
    wire cmp_hit = (addr == AW'(cmp_ofs(c)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_buf[c] <= '0;
        cmp_buf[c] <= '0;
      end else if (wr_en) begin
        if (cnt_hit) cnt_buf[c] <= wdata[CW-1:0];
        if (cmp_hit) cmp_buf[c] <= wdata[CW-1:0];
      end
    end

    assign ctl[c].run  = ctrl_q[NB];
    assign ctl[c].load = ctrl_q[NB+1];
    if (c == LAST) begin : g_nopin
      assign ctl[c].inv = 1'b0;
    end else begin : g_pin
      assign ctl[c].inv = ctrl_q[NB+2];
    end
    assign ctl[c].rep  = ctrl_q[RB];
  end

  always_comb begin
    rdata = '0;
    if (ctrl_hit) rdata = ctrl_q;
    for (int c = 0; c < NCHAN; c++) begin
      if (addr == AW'(cnt_ofs(c))) rdata = DW'(cnt_buf[c]);
      if (addr == AW'(cmp_ofs(c))) rdata = DW'(cmp_buf[c]);
    end
  end

  // R2: unused control bits never read back as one
  a_r2_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_hit |-> ((rdata & ~CTRL_MASK) == '0));

  // R10: buffers move only on a write cycle
  a_r10_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(cnt_buf) && $stable(cmp_buf)));

endmodule

// File: rtl/pwmt_counter.sv
`timescale 1ns/1ps
module pwmt_counter
  import pwmt_pkg::*;
#(
  parameter int CW      = 32,
  parameter bit HAS_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  chan_ctl_t     ctl,
  input  logic [CW-1:0] cnt_buf,
  input  logic [CW-1:0] cmp_buf,
  output logic          pwm,
  output logic          expire
);

  logic [CW-1:0] cnt_q, cmp_q;
  logic          done_q, exp_q;

  wire at_zero = (cnt_q == '0);
  wire step    = ctl.run && tick && !ctl.load && !done_q;
  wire fire    = step && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmp_q  <= '0;
      done_q <= 1'b0;
      exp_q  <= 1'b0;
    end else begin
      exp_q <= fire;
      if (ctl.load) begin
        cnt_q  <= cnt_buf;
        cmp_q  <= cmp_buf;
        done_q <= 1'b0;
      end else if (step) begin
        if (at_zero) begin
          if (ctl.rep) begin
            cnt_q <= cnt_buf;
            cmp_q <= cmp_buf;
          end else begin
            done_q <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign expire = exp_q;

  if (HAS_OUT) begin : g_out
    wire raw = (cmp_q == '1) || (cnt_q > cmp_q);
    assign pwm = (ctl.run && raw) ^ ctl.inv;

    // R8: full-duty compare keeps the pin at its active level
    a_r8_full_duty: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.run && cmp_q == '1) |-> (pwm == !ctl.inv));
  end else begin : g_noout
    assign pwm = 1'b0;
  end

  // R4: load copies both buffers
  a_r4_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.load |=> (cnt_q == $past(cnt_buf) && cmp_q == $past(cmp_buf)));

  // R5: no tick or no run means the counter holds
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((!tick || !ctl.run) && !ctl.load) |=> $stable(cnt_q));

  // R6: an expiry pulse follows a zero count
  a_r6_expire_zero: assert property (@(posedge clk) disable iff (!rst_n)
    exp_q |-> ($past(cnt_q) == '0));

  // R7: one-shot stop parks the counter at zero
  a_r7_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_q && !$past(ctl.rep)) |-> (cnt_q == '0 && done_q));

endmodule

// File: rtl/pwm_timer_bank.sv
`timescale 1ns/1ps
module pwm_timer_bank
  import pwmt_pkg::*;
#(
  parameter int NCHAN = 5,
  parameter int CW    = 32,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCHAN-1:0] tick_i,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic [NCHAN-2:0] pwm_o,
  output logic [NCHAN-1:0] expire_o
);

  localparam int NOUT = NCHAN - 1;

  chan_ctl_t [NCHAN-1:0]    ctl;
  logic [NCHAN-1:0][CW-1:0] cnt_buf, cmp_buf;
  logic [NCHAN-1:0]         pwm_all;

  pwmt_regs #(.NCHAN(NCHAN), .CW(CW), .AW(AW), .DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .ctl     (ctl),
    .cnt_buf (cnt_buf),
    .cmp_buf (cmp_buf)
  );

  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    pwmt_counter #(.CW(CW), .HAS_OUT(c < NOUT)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_i[c]),
      .ctl     (ctl[c]),
      .cnt_buf (cnt_buf[c]),
      .cmp_buf (cmp_buf[c]),
      .pwm     (pwm_all[c]),
      .expire  (expire_o[c])
    );
  end

  assign pwm_o = pwm_all[NOUT-1:0];

  // R9: the pinless channel never drives a level
  a_r9_no_pin: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_all[NCHAN-1] == 1'b0);

endmodule

// File: tb/sim_pwm_timer_bank.sv
`timescale 1ns/1ps
module sim_pwm_timer_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  tick_i = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  pwm_o;
  logic [4:0]  expire_o;

  always #2.5 clk = ~clk;

  pwm_timer_bank u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pwm_o(pwm_o), .expire_o(expire_o)
  );

  int total = 0;
  int bad = 0;
  string phase = "R3 reset";

  int NIB [5] = '{0, 8, 12, 16, 20};
  int REPB[5] = '{3, 11, 15, 19, 22};

  logic [31:0] m_ctrl;
  logic [31:0] m_cb[5], m_pb[5], m_cnt[5], m_cmp[5];
  bit          m_done[5], m_exp[5];

  task automatic model_reset();
    m_ctrl = 32'h0004_4404;
    for (int c = 0; c < 5; c++) begin
      m_cb[c] = 0; m_pb[c] = 0; m_cnt[c] = 0; m_cmp[c] = 0;
      m_done[c] = 0; m_exp[c] = 0;
    end
  endtask

  task automatic model_step();
    bit run, ld, rep;
    if (!rst_n) begin
      model_reset();
      return;
    end
    for (int c = 0; c < 5; c++) begin
      run = m_ctrl[NIB[c]];
      ld  = m_ctrl[NIB[c] + 1];
      rep = m_ctrl[REPB[c]];
      m_exp[c] = run && tick_i[c] && !ld && m_cnt[c] == 0 && !m_done[c];
      if (ld) begin
        m_cnt[c] = m_cb[c]; m_cmp[c] = m_pb[c]; m_done[c] = 0;
      end else if (run && tick_i[c] && !m_done[c]) begin
        if (m_cnt[c] == 0) begin
          if (rep) begin m_cnt[c] = m_cb[c]; m_cmp[c] = m_pb[c]; end
          else m_done[c] = 1;
        end else begin
          m_cnt[c] = m_cnt[c] - 1;
        end
      end
    end
    if (reg_wr) begin
      if (reg_addr == 8'h08) m_ctrl = reg_wdata & 32'h007F_FF0F;
      for (int c = 0; c < 5; c++) begin
        if (reg_addr == 8'(12 + 12 * c)) m_cb[c] = reg_wdata;
        if (reg_addr == 8'(16 + 12 * c)) m_pb[c] = reg_wdata;
      end
    end
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s (%s) got=%h exp=%h", tag, phase, got, exp);
    end
  endtask

  task automatic compare();
    logic [3:0]  ep;
    logic [4:0]  ee;
    logic [31:0] er;
    bit run, raw;
    for (int c = 0; c < 4; c++) begin
      run = m_ctrl[NIB[c]];
      raw = (m_cmp[c] == 32'hFFFF_FFFF) || (m_cnt[c] > m_cmp[c]);
      ep[c] = (run && raw) ^ m_ctrl[NIB[c] + 2];
    end
    for (int c = 0; c < 5; c++) ee[c] = m_exp[c];
    er = 0;
    if (reg_addr == 8'h08) er = m_ctrl;
    for (int c = 0; c < 5; c++) begin
      if (reg_addr == 8'(12 + 12 * c)) er = m_cb[c];
      if (reg_addr == 8'(16 + 12 * c)) er = m_pb[c];
    end
    chk("R8", {28'd0, pwm_o}, {28'd0, ep});
    chk("R6", {27'd0, expire_o}, {27'd0, ee});
    chk("R1", reg_rdata, er);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    reg_addr = a;
    cyc();
  endtask

  // period 1: ticks every cycle; period 3: one tick in three
  task automatic run_for(input int n, input int per);
    for (int i = 0; i < n; i++) begin
      tick_i = (i % per == 0) ? 5'b11111 : 5'b00000;
      cyc();
    end
    tick_i = '0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    model_reset();
    repeat (3) cyc();
    rst_n = 1'b1;
    // R3: reset values through the bus
    rd(8'h08); chk("R3", reg_rdata, 32'h0004_4404);
    chk("R3", {28'd0, pwm_o}, 32'h0000_000F);
    rd(8'h0C); rd(8'h40);

    phase = "R1 R10 map";
    for (int c = 0; c < 5; c++) begin
      wr(8'(12 + 12 * c), 32'h100 + c);
      wr(8'(16 + 12 * c), 32'h200 + c);
    end
    for (int c = 0; c < 5; c++) begin rd(8'(12 + 12 * c)); rd(8'(16 + 12 * c)); end
    rd(8'h00); rd(8'h04); rd(8'h0D); rd(8'h44); rd(8'hFC);

    phase = "R2 R4 ctrl gaps and held load";
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08); chk("R2", reg_rdata, 32'h007F_FF0F);
    run_for(4, 1);
    wr(8'h08, 32'h0000_0000);

    phase = "R6 R8 R9 repeat run";
    wr(8'h0C, 9);  wr(8'h10, 4);
    wr(8'h18, 6);  wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h24, 5);  wr(8'h28, 0);
    wr(8'h30, 3);  wr(8'h34, 1);
    wr(8'h3C, 4);  wr(8'h40, 0);
    wr(8'h08, 32'h0022_2202);
    wr(8'h08, 32'h005D_9D09);
    reg_addr = 8'h08;
    run_for(40, 1);

    phase = "R5 sparse ticks";
    run_for(30, 3);

    phase = "R10 buffer write mid-period";
    wr(8'h0C, 2);
    wr(8'h34, 0);
    run_for(30, 1);

    phase = "R7 one-shot";
    wr(8'h08, 32'h005D_3D09);
    wr(8'h08, 32'h005D_1D09);
    run_for(20, 1);

    phase = "R9 pinless one-shot";
    wr(8'h08, 32'h0012_1D09);
    wr(8'h08, 32'h0011_1D09);
    run_for(20, 1);

    phase = "R5 stopped";
    wr(8'h08, 32'h0004_4404);
    run_for(10, 1);

    phase = "R4 load held while ticking";
    wr(8'h08, 32'h0026_6606);
    run_for(5, 1);
    wr(8'h08, 32'h005D_9D09);
    run_for(25, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule